// File: doc/BRIEF.md
# General-Purpose Output Selector with Reference Clock Divider

This block decides what a single general-purpose output pin carries. A 3-bit selector picks one of several internal sources. The sources are a divided copy of the reference clock, the serial interface's data-out line, an oscillator-missing flag, a PLL-ready flag and the transmit data bit. One selector code shares the pin between the divided clock and serial data out, and the chip-select level decides which of the two is shown. Two codes are reserved.

The divided clock comes from a power-of-two divider with a 3-bit code. It runs only while a clock-output enable is set. When the enable is clear, the divider counter is held at zero and the clock source is low. A new divider code is applied only where a new divided-clock period begins, so a change never shortens a high or a low phase. Divide-by-1 passes the reference clock through, gated by a registered run flag that changes only at rising reference edges. The pad driver lies outside the block.

Top module: `gpo_pin_select`

## Requirements
- R1: Divider code 0, 1, 2 and 3 give periods of 1, 2, 4 and 8 reference cycles, and codes 4 to 7 all give 16. For each period of N ≥ 2 the divided clock is high for the first N/2 cycles and low for the last N/2 cycles.
- R2: Selector code 0 puts the divided clock on the pin while `cs_n` is 1, and `sdo` on the pin while `cs_n` is 0.
- R3: Selector code 1 always puts `sdo` on the pin, and selector code 2 always puts the divided clock on the pin.
- R4: Selector code 5 puts `osc_missing` on the pin, code 6 puts `pll_ready` on the pin, and code 7 puts `tx_bit` on the pin.
- R5: Selector codes 3 and 4 drive the pin low, whatever the other inputs are.
- R6: While `clk_out_en` is 0 the clock source is low, from the first rising edge that samples it at 0. After an enable, the first rising edge that samples it at 1 begins a high phase that starts at count zero.
- R7: A divider code change made during a period takes effect only at the next divided-clock rising edge. The period in progress completes with its old length.
- R8: With divider code 0 and the clock enabled, the pin follows the reference clock: it is high while `clk` is high and low while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpo_sel | input | 3 | Pin source selector |
| div_code | input | 3 | Divider code (power-of-two ratio, saturating at 16) |
| clk_out_en | input | 1 | Enables the divided clock source |
| cs_n | input | 1 | Serial interface chip select, active low |
| sdo | input | 1 | Serial data out from the serial interface |
| osc_missing | input | 1 | Flag: reference oscillator not running |
| pll_ready | input | 1 | Flag: PLL ready |
| tx_bit | input | 1 | Transmit data bit |
| gpo | output | 1 | General-purpose output pin value |

## Verification
The selector paths are combinational, so the bench checks them in the same cycle, a full time unit after the inputs are driven. The divided clock is registered. The bench drives inputs just after a rising edge, and the first effect of an enable or disable appears after the next rising edge. The bench samples one time unit after each edge, counts edges from the enabling one, and expects phase (k−1) mod N to be high for the first half of each period. For divide-by-1 it samples in both halves of each reference cycle. For a divider change it keeps counting the old period until its last cycle, then expects a high phase with the new length.

// File: rtl/gpo_pkg.sv
`timescale 1ns/1ps
package gpo_pkg;

  localparam int unsigned GPO_SEL_W   = 3;
  localparam int unsigned GPO_CODE_W  = 3;
  localparam int unsigned GPO_MAX_LOG = 4;

  typedef enum logic [GPO_SEL_W-1:0] {
    SRC_CLK_OR_SDO = 3'd0,
    SRC_SDO        = 3'd1,
    SRC_CLK        = 3'd2,
    SRC_RSV_A      = 3'd3,
    SRC_RSV_B      = 3'd4,
    SRC_OSC_MISS   = 3'd5,
    SRC_PLL_RDY    = 3'd6,
    SRC_TX_BIT     = 3'd7
  } gpo_src_e;

  // log2 of the divide ratio: the code itself, clipped at the ceiling
  function automatic int unsigned div_log2(input int unsigned code,
                                           input int unsigned ceiling);
    return (code > ceiling) ? ceiling : code;
  endfunction

  // length of one divided period in reference cycles
  function automatic int unsigned div_len(input int unsigned code,
                                          input int unsigned ceiling);
    return 1 << div_log2(code, ceiling);
  endfunction

endpackage

// File: rtl/gpo_clk_divider.sv
`timescale 1ns/1ps
module gpo_clk_divider
  import gpo_pkg::*;
#(
  parameter int unsigned CODE_W  = GPO_CODE_W,
  parameter int unsigned MAX_LOG = GPO_MAX_LOG,
  localparam int unsigned CNT_W  = (MAX_LOG < 1) ? 1 : MAX_LOG,
  localparam int unsigned LEN_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [CODE_W-1:0] div_code,
  output logic              clk_out,
  output logic              period_end
);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CODE_W-1:0] code_q;
  logic              run_q;
  logic              dclk_q;
  logic [LEN_W-1:0]  len_cur;
  logic [LEN_W-1:0]  half_cur;
  logic              wrap;
  logic              bypass;

  always_comb begin
    len_cur  = LEN_W'(div_len(int'(code_q), MAX_LOG));
    half_cur = len_cur >> 1;
    cnt_inc  = cnt_q + CNT_W'(1);
    wrap     = !run_q || ({1'b0, cnt_q} == (len_cur - LEN_W'(1)));
    bypass   = (div_log2(int'(code_q), MAX_LOG) == 0);
  end

  // event: a new divided period begins on the coming edge
  assign period_end = clk_en && run_q && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
      run_q  <= 1'b0;
      dclk_q <= 1'b0;
    end else if (!clk_en) begin
      cnt_q  <= '0;
      code_q <= div_code;
      run_q  <= 1'b0;
      dclk_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (wrap) begin
        cnt_q  <= '0;
        code_q <= div_code;
        dclk_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_inc;
        dclk_q <= ({1'b0, cnt_inc} < half_cur);
      end
    end
  end

  // divide-by-1 passes the reference, gated by a flag that changes at rising edges
  assign clk_out = bypass ? (clk & run_q) : dclk_q;

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ({1'b0, cnt_q} < len_cur));

  assert_off_is_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (!dclk_q && !run_q && (cnt_q == '0)));

  assert_start_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !run_q) |=> (dclk_q && (cnt_q == '0)));

  assert_code_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && run_q && !wrap) |=> $stable(code_q));

  assert_rise_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && run_q && !wrap) |=> !$rose(dclk_q));

endmodule

// File: rtl/gpo_source_mux.sv
`timescale 1ns/1ps
module gpo_source_mux
  import gpo_pkg::*;
(
  input  gpo_src_e sel,
  input  logic     clk_src,
  input  logic     cs_n,
  input  logic     sdo,
  input  logic     osc_missing,
  input  logic     pll_ready,
  input  logic     tx_bit,
  output logic     pin
);

  always_comb begin
    unique case (sel)
      SRC_CLK_OR_SDO: pin = cs_n ? clk_src : sdo;
      SRC_SDO:        pin = sdo;
      SRC_CLK:        pin = clk_src;
      SRC_OSC_MISS:   pin = osc_missing;
      SRC_PLL_RDY:    pin = pll_ready;
      SRC_TX_BIT:     pin = tx_bit;
      default:        pin = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpo_pin_select.sv
`timescale 1ns/1ps
module gpo_pin_select
  import gpo_pkg::*;
#(
  parameter int unsigned CODE_W  = GPO_CODE_W,
  parameter int unsigned MAX_LOG = GPO_MAX_LOG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GPO_SEL_W-1:0] gpo_sel,
  input  logic [CODE_W-1:0]    div_code,
  input  logic                 clk_out_en,
  input  logic                 cs_n,
  input  logic                 sdo,
  input  logic                 osc_missing,
  input  logic                 pll_ready,
  input  logic                 tx_bit,
  output logic                 gpo
);

  logic     div_clk;
  logic     div_period_end;
  gpo_src_e sel_e;

  assign sel_e = gpo_src_e'(gpo_sel);

  gpo_clk_divider #(
    .CODE_W  (CODE_W),
    .MAX_LOG (MAX_LOG)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_out_en),
    .div_code   (div_code),
    .clk_out    (div_clk),
    .period_end (div_period_end)
  );

  gpo_source_mux u_mux (
    .sel         (sel_e),
    .clk_src     (div_clk),
    .cs_n        (cs_n),
    .sdo         (sdo),
    .osc_missing (osc_missing),
    .pll_ready   (pll_ready),
    .tx_bit      (tx_bit),
    .pin         (gpo)
  );

  assert_shared_sdo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gpo_sel == 3'd0 && !cs_n) |-> (gpo == sdo));

  assert_sdo_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gpo_sel == 3'd1) |-> (gpo == sdo));

  assert_osc_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gpo_sel == 3'd5) |-> (gpo == osc_missing));

  assert_reserved_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gpo_sel == 3'd3 || gpo_sel == 3'd4) |-> !gpo);

  assert_clk_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gpo_sel == 3'd2 && !clk_out_en) |=> (gpo_sel != 3'd2 || !gpo));

endmodule

// File: tb/sim_gpo_pin_select.sv
`timescale 1ns/1ps
module sim_gpo_pin_select;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] gpo_sel = 3'd2;
  logic [2:0] div_code = 3'd0;
  logic       clk_out_en = 1'b0;
  logic       cs_n = 1'b1;
  logic       sdo = 1'b0;
  logic       osc_missing = 1'b0;
  logic       pll_ready = 1'b0;
  logic       tx_bit = 1'b0;
  logic       gpo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpo_pin_select u0 (
    .clk(clk), .rst_n(rst_n), .gpo_sel(gpo_sel), .div_code(div_code),
    .clk_out_en(clk_out_en), .cs_n(cs_n), .sdo(sdo),
    .osc_missing(osc_missing), .pll_ready(pll_ready), .tx_bit(tx_bit),
    .gpo(gpo)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // sample point: one time unit after a rising edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int len_of(input int code);
    return (code >= 4) ? 16 : (1 << code);
  endfunction

  task automatic t_reset();
    gpo_sel = 3'd2; clk_out_en = 1'b0;
    tick();
    chk("R6", "reset clock source low", gpo, 1'b0);
  endtask

  task automatic t_mux_paths();
    gpo_sel = 3'd1; sdo = 1'b1; #1; chk("R3", "sel1 sdo=1", gpo, 1'b1);
    sdo = 1'b0; #1; chk("R3", "sel1 sdo=0", gpo, 1'b0);
    gpo_sel = 3'd0; cs_n = 1'b0; sdo = 1'b1; #1; chk("R2", "sel0 cs low sdo=1", gpo, 1'b1);
    sdo = 1'b0; #1; chk("R2", "sel0 cs low sdo=0", gpo, 1'b0);
    cs_n = 1'b1; #1; chk("R2", "sel0 cs high disabled clock", gpo, 1'b0);
    gpo_sel = 3'd5; osc_missing = 1'b1; #1; chk("R4", "sel5 flag=1", gpo, 1'b1);
    osc_missing = 1'b0; #1; chk("R4", "sel5 flag=0", gpo, 1'b0);
    gpo_sel = 3'd6; pll_ready = 1'b1; #1; chk("R4", "sel6 ready=1", gpo, 1'b1);
    pll_ready = 1'b0; #1; chk("R4", "sel6 ready=0", gpo, 1'b0);
    gpo_sel = 3'd7; tx_bit = 1'b1; #1; chk("R4", "sel7 bit=1", gpo, 1'b1);
    tx_bit = 1'b0; #1; chk("R4", "sel7 bit=0", gpo, 1'b0);
    sdo = 1'b1; osc_missing = 1'b1; pll_ready = 1'b1; tx_bit = 1'b1; cs_n = 1'b0;
    gpo_sel = 3'd3; #1; chk("R5", "sel3 low", gpo, 1'b0);
    gpo_sel = 3'd4; #1; chk("R5", "sel4 low", gpo, 1'b0);
    sdo = 1'b0; osc_missing = 1'b0; pll_ready = 1'b0; tx_bit = 1'b0; cs_n = 1'b1;
  endtask

  // enable with a given code and compare against the expected waveform
  task automatic t_wave(input int code, input logic [2:0] sel);
    gpo_sel = sel; clk_out_en = 1'b0; div_code = 3'(code);
    tick();
    chk("R6", "disabled before run", gpo, 1'b0);
    clk_out_en = 1'b1;
    if (code == 0) begin
      for (int k = 0; k < 4; k++) begin
        tick();
        chk("R8", "div1 high half", gpo, 1'b1);
        @(negedge clk); #1;
        chk("R8", "div1 low half", gpo, 1'b0);
      end
    end else begin
      for (int k = 1; k <= 2 * len_of(code); k++) begin
        tick();
        chk("R1", $sformatf("code %0d edge %0d", code, k), gpo,
            ((k - 1) % len_of(code)) < (len_of(code) / 2));
      end
    end
    clk_out_en = 1'b0;
    tick();
    chk("R6", "low after disable", gpo, 1'b0);
  endtask

  task automatic t_disable_mid();
    gpo_sel = 3'd2; div_code = 3'd3; clk_out_en = 1'b1;
    tick(); tick();
    chk("R1", "div8 second cycle high", gpo, 1'b1);
    clk_out_en = 1'b0;
    tick();
    chk("R6", "disable mid high", gpo, 1'b0);
    clk_out_en = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      chk("R6", $sformatf("restart from zero edge %0d", k), gpo, k <= 4);
    end
    clk_out_en = 1'b0; tick();
  endtask

  task automatic t_code_change();
    logic exp_seq [5] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    gpo_sel = 3'd2; div_code = 3'd2; clk_out_en = 1'b1;
    tick();
    chk("R7", "div4 phase0", gpo, 1'b1);
    tick();
    chk("R7", "div4 phase1", gpo, 1'b1);
    div_code = 3'd1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R7", $sformatf("change step %0d", k), gpo, exp_seq[k]);
    end
    clk_out_en = 1'b0; tick();
  endtask

  task automatic t_shared_clock();
    gpo_sel = 3'd0; cs_n = 1'b1; div_code = 3'd1; clk_out_en = 1'b1;
    tick(); chk("R2", "sel0 cs high clock high", gpo, 1'b1);
    tick(); chk("R2", "sel0 cs high clock low", gpo, 1'b0);
    cs_n = 1'b0; sdo = 1'b1; #1; chk("R2", "sel0 cs low shows sdo", gpo, 1'b1);
    cs_n = 1'b1; sdo = 1'b0; clk_out_en = 1'b0; tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_mux_paths();
    for (int c = 0; c < 8; c++) t_wave(c, 3'd2);
    t_wave(3, 3'd0);
    t_disable_mid();
    t_code_change();
    t_shared_clock();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule